// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block controls a set of switchable power domains. Each domain owns one bit position across a small register bank. Each domain has four control outputs: a clock enable, a reset release, an isolation enable and a power-switch off request. It also has one acknowledge input that comes back from its analog power switch. Software does not drive these outputs directly. It writes a command, and a per-domain hardware sequencer then steps the outputs in a safe order.

A power-down command gates the clock first, then isolates the domain, then holds it in reset, and finally opens the power switch. A programmable settle interval, counted in clock cycles, is inserted after each of the first three steps. The sequence ends when the switch acknowledges the off state. A power-up command reverses the order. It first closes the switch and waits for the acknowledge to drop. It then releases reset, removes isolation and restarts the clock, with a settle interval after each of these steps.

Each acknowledge wait is bounded. The bound for power-down and the bound for power-up are separate parameters. If a bound runs out, the sequence stops and a sticky per-domain error bit is set. The acknowledge inputs are asynchronous, so each bit passes through a two-flop synchroniser before it is used.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, every domain is powered on: clock enable 1, reset release 1, isolation 0, switch-off request 0. Busy and error both read 0.
- R2: A power-down command to an idle domain clears its clock enable at the command edge. Isolation rises SETTLE_CYC cycles later. Reset release falls 2*SETTLE_CYC cycles after the command edge, and the switch-off request rises 3*SETTLE_CYC cycles after it.
- R3: After the switch-off request rises, the power-down sequence stays busy until the synchronised acknowledge reads 1. It then returns to idle with no error.
- R4: A power-up command clears the switch-off request at the command edge. Reset release rises on the first edge at which the synchronised acknowledge reads 0. Isolation falls SETTLE_CYC cycles after that edge, and the clock enable rises 2*SETTLE_CYC cycles after it. Busy clears 3*SETTLE_CYC cycles after it.
- R5: If the acknowledge does not reach the wanted level within DN_POLL sampling cycles (power-down) or UP_POLL sampling cycles (power-up), the sequence stops at that point. Busy clears on the edge that ends the window, the domain's error bit is set, and all other outputs keep their values.
- R6: A command written to a domain whose busy bit is 1 is ignored.
- R7: Writing 1 to a bit of the error register clears that domain's error. Writing 0 leaves it unchanged.
- R8: The register map is fixed. Offset 0x00 is the command register (write): bit d requests power-down of domain d and bit 16+d requests power-up. The read-only registers are 0x04 clock enables, 0x08 reset releases, 0x0C isolation, 0x10 switch-off requests, 0x14 synchronised acknowledges and 0x18 busy. Offset 0x1C is the error register (read, write-1-to-clear). Bit d of each register belongs to domain d, and unmapped offsets read 0.
- R9: If one write sets both the power-down and the power-up bit of the same domain, power-down is performed.
- R10: Several domains commanded in one write sequence independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 8 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read byte offset |
| bus_rdata | output | 32 | Read data (combinational from bus_raddr) |
| pwr_ack | input | NUM_DOM | Asynchronous switch acknowledge, 1 = switch off |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_rst_rel | output | NUM_DOM | Per-domain reset release (0 = held in reset) |
| dom_iso | output | NUM_DOM | Per-domain isolation enable |
| dom_pwr_off | output | NUM_DOM | Per-domain power-switch off request |

## Verification
The assertions check the step order on every cycle. Isolation may rise only while the clock is gated. Reset may be asserted only under isolation. The switch may open only with all three protections in place. On the way up, reset may be released only once the acknowledge is low, and the clock may return only after every other step is done. The assertions also check the reset state and that an error appears only at the end of an acknowledge wait. The bench's scenarios are the only proof of the exact settle spacing, the exact timeout windows, ignored commands, write-1-to-clear and simultaneous multi-domain sequencing. They sweep every domain under a switch model with random latency and a stuck acknowledge.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int REG_AW     = 8;
    localparam int REG_DW     = 32;
    localparam int CMD_UP_LSB = 16;

    localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CLK  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_RST  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_ISO  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_PDN  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_ACK  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_BUSY = 8'h18;
    localparam logic [REG_AW-1:0] OFS_ERR  = 8'h1C;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_RST,
        ST_DN_PDN,
        ST_DN_ACK,
        ST_UP_ACK,
        ST_UP_ISO,
        ST_UP_CLK,
        ST_UP_END
    } seq_state_e;

    typedef struct packed {
        logic clk_en;
        logic rst_rel;
        logic iso;
        logic pdn;
    } dom_ctl_t;

    localparam dom_ctl_t CTL_POWERED = '{clk_en: 1'b1, rst_rel: 1'b1, iso: 1'b0, pdn: 1'b0};

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end
endmodule

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int NUM_DOM = 7
) (
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_waddr,
    input  logic [REG_DW-1:0]   bus_wdata,
    input  logic [REG_AW-1:0]   bus_raddr,
    output logic [REG_DW-1:0]   bus_rdata,
    input  logic [NUM_DOM-1:0]  clk_v,
    input  logic [NUM_DOM-1:0]  rst_v,
    input  logic [NUM_DOM-1:0]  iso_v,
    input  logic [NUM_DOM-1:0]  pdn_v,
    input  logic [NUM_DOM-1:0]  ack_v,
    input  logic [NUM_DOM-1:0]  busy_v,
    input  logic [NUM_DOM-1:0]  err_v,
    output logic [NUM_DOM-1:0]  dn_req,
    output logic [NUM_DOM-1:0]  up_req,
    output logic [NUM_DOM-1:0]  err_clr
);
    logic cmd_hit, err_hit;
    logic [NUM_DOM-1:0] dn_bits, up_bits;

    assign cmd_hit = bus_wr && (bus_waddr == OFS_CMD);
    assign err_hit = bus_wr && (bus_waddr == OFS_ERR);
    assign dn_bits = bus_wdata[NUM_DOM-1:0];
    assign up_bits = bus_wdata[CMD_UP_LSB +: NUM_DOM];

    // R9: a power-down bit masks the power-up bit of the same domain
    assign dn_req  = cmd_hit ? dn_bits : '0;
    assign up_req  = cmd_hit ? (up_bits & ~dn_bits) : '0;
    assign err_clr = err_hit ? bus_wdata[NUM_DOM-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            OFS_CLK:  bus_rdata[NUM_DOM-1:0] = clk_v;
            OFS_RST:  bus_rdata[NUM_DOM-1:0] = rst_v;
            OFS_ISO:  bus_rdata[NUM_DOM-1:0] = iso_v;
            OFS_PDN:  bus_rdata[NUM_DOM-1:0] = pdn_v;
            OFS_ACK:  bus_rdata[NUM_DOM-1:0] = ack_v;
            OFS_BUSY: bus_rdata[NUM_DOM-1:0] = busy_v;
            OFS_ERR:  bus_rdata[NUM_DOM-1:0] = err_v;
            default:  bus_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/pds_domain_fsm.sv
module pds_domain_fsm
    import pds_pkg::*;
#(
    parameter int SETTLE_CYC = 500,
    parameter int DN_POLL    = 1000,
    parameter int UP_POLL    = 10000,
    parameter int CNT_W      = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     dn_req,
    input  logic     up_req,
    input  logic     err_clr,
    input  logic     ack_s,
    output dom_ctl_t ctl,
    output logic     busy,
    output logic     err
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             settle_done, dn_expired, up_expired;

    assign settle_done = (cnt_q == CNT_W'(SETTLE_CYC - 1));
    assign dn_expired  = (cnt_q == CNT_W'(DN_POLL - 1));
    assign up_expired  = (cnt_q == CNT_W'(UP_POLL - 1));
    assign busy        = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctl     <= CTL_POWERED;
            err     <= 1'b0;
        end else begin
            if (err_clr) err <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (dn_req) begin
                        ctl.clk_en <= 1'b0;
                        state_q    <= ST_DN_ISO;
                    end else if (up_req) begin
                        ctl.pdn <= 1'b0;
                        state_q <= ST_UP_ACK;
                    end
                end
                ST_DN_ISO: begin
                    if (settle_done) begin
                        ctl.iso <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_DN_RST;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_DN_RST: begin
                    if (settle_done) begin
                        ctl.rst_rel <= 1'b0;
                        cnt_q       <= '0;
                        state_q     <= ST_DN_PDN;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_DN_PDN: begin
                    if (settle_done) begin
                        ctl.pdn <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_DN_ACK;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_DN_ACK: begin
                    if (ack_s) begin
                        state_q <= ST_IDLE;
                    end else if (dn_expired) begin
                        err     <= 1'b1;
                        state_q <= ST_IDLE;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_UP_ACK: begin
                    if (!ack_s) begin
                        ctl.rst_rel <= 1'b1;
                        cnt_q       <= '0;
                        state_q     <= ST_UP_ISO;
                    end else if (up_expired) begin
                        err     <= 1'b1;
                        state_q <= ST_IDLE;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_UP_ISO: begin
                    if (settle_done) begin
                        ctl.iso <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_UP_CLK;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_UP_CLK: begin
                    if (settle_done) begin
                        ctl.clk_en <= 1'b1;
                        cnt_q      <= '0;
                        state_q    <= ST_UP_END;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_UP_END: begin
                    if (settle_done) state_q <= ST_IDLE;
                    else cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r1_reset_powered: assert property (@(posedge clk)
        rst |=> (ctl == CTL_POWERED) && !err && !busy);

    a_r2_iso_needs_gated_clk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.iso) |-> !ctl.clk_en);

    a_r2_reset_needs_iso: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.rst_rel) |-> ctl.iso && !ctl.clk_en);

    a_r2_switch_needs_all: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.pdn) |-> !ctl.rst_rel && ctl.iso && !ctl.clk_en);

    a_r4_release_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.rst_rel) |-> !ctl.pdn && !$past(ack_s));

    a_r4_clock_last: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.clk_en) |-> ctl.rst_rel && !ctl.iso && !ctl.pdn);

    a_r5_error_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(state_q) == ST_DN_ACK) || ($past(state_q) == ST_UP_ACK));

    a_r6_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DN_ISO && !settle_done) |=> state_q == ST_DN_ISO);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pds_pkg::*;
#(
    parameter int NUM_DOM    = 7,
    parameter int SETTLE_CYC = 500,
    parameter int DN_POLL    = 1000,
    parameter int UP_POLL    = 10000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [7:0]          bus_waddr,
    input  logic [31:0]         bus_wdata,
    input  logic [7:0]          bus_raddr,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_DOM-1:0]  pwr_ack,
    output logic [NUM_DOM-1:0]  dom_clk_en,
    output logic [NUM_DOM-1:0]  dom_rst_rel,
    output logic [NUM_DOM-1:0]  dom_iso,
    output logic [NUM_DOM-1:0]  dom_pwr_off
);
    localparam int CNT_W = $clog2(max3(SETTLE_CYC, DN_POLL, UP_POLL) + 1);

    logic [NUM_DOM-1:0] ack_s, dn_req, up_req, err_clr, busy_v, err_v;
    dom_ctl_t           ctl [NUM_DOM];

    pds_sync #(.WIDTH(NUM_DOM)) u_sync (
        .clk(clk), .rst(rst), .d_async(pwr_ack), .q(ack_s)
    );

    pds_regs #(.NUM_DOM(NUM_DOM)) u_regs (
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .clk_v(dom_clk_en), .rst_v(dom_rst_rel), .iso_v(dom_iso),
        .pdn_v(dom_pwr_off), .ack_v(ack_s), .busy_v(busy_v), .err_v(err_v),
        .dn_req(dn_req), .up_req(up_req), .err_clr(err_clr)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        pds_domain_fsm #(
            .SETTLE_CYC(SETTLE_CYC), .DN_POLL(DN_POLL),
            .UP_POLL(UP_POLL), .CNT_W(CNT_W)
        ) u_fsm (
            .clk(clk), .rst(rst),
            .dn_req(dn_req[g]), .up_req(up_req[g]), .err_clr(err_clr[g]),
            .ack_s(ack_s[g]), .ctl(ctl[g]), .busy(busy_v[g]), .err(err_v[g])
        );
        assign dom_clk_en[g]  = ctl[g].clk_en;
        assign dom_rst_rel[g] = ctl[g].rst_rel;
        assign dom_iso[g]     = ctl[g].iso;
        assign dom_pwr_off[g] = ctl[g].pdn;
    end
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    import pds_pkg::*;

    localparam int N  = 4;
    localparam int S  = 3;
    localparam int DN = 8;
    localparam int UP = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [7:0] bus_waddr = '0, bus_raddr = OFS_BUSY;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] ack_raw, clk_en, rst_rel, iso, pdn;
    logic [N-1:0] stuck_en = '0, stuck_val = '0;
    int sw_dly [N];
    int sw_cnt [N];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_seq_ctrl #(.NUM_DOM(N), .SETTLE_CYC(S), .DN_POLL(DN), .UP_POLL(UP)) i_pwr_seq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .pwr_ack(ack_raw), .dom_clk_en(clk_en), .dom_rst_rel(rst_rel),
        .dom_iso(iso), .dom_pwr_off(pdn)
    );

    // power switch model: follows the off request after a random latency
    always @(posedge clk) begin
        for (int d = 0; d < N; d++) begin
            if (rst) begin
                ack_raw[d] <= 1'b0;
                sw_cnt[d]  <= 0;
            end else if (stuck_en[d]) begin
                ack_raw[d] <= stuck_val[d];
            end else if (pdn[d] != ack_raw[d]) begin
                if (sw_cnt[d] >= sw_dly[d]) begin
                    ack_raw[d] <= pdn[d];
                    sw_cnt[d]  <= 0;
                end else sw_cnt[d] <= sw_cnt[d] + 1;
            end else sw_cnt[d] <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dat);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = dat;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] dat);
        bus_raddr = a; #1;
        dat = bus_rdata;
        bus_raddr = OFS_BUSY;
    endtask

    function automatic logic [3:0] ctl_of(input int d);
        return {clk_en[d], rst_rel[d], iso[d], pdn[d]};
    endfunction

    task automatic run_down(input int d, input bit stuck);
        bit bad = 0;
        bit fin = 0;
        logic [31:0] v;
        sw_dly[d] = $urandom_range(0, 3);
        if (stuck) begin stuck_val[d] = 1'b0; stuck_en[d] = 1'b1; end
        bus_raddr = OFS_BUSY;
        wr(OFS_CMD, 32'(1) << d);
        for (int k = 0; k <= 3*S; k++) begin
            @(negedge clk);
            if (clk_en[d] !== 1'b0 || iso[d] !== (k >= S) ||
                rst_rel[d] !== (k < 2*S) || pdn[d] !== (k >= 3*S)) bad = 1;
        end
        chk(!bad, $sformatf("R2 down order dom%0d", d), ctl_of(d), 4'b0011);
        if (stuck) begin
            for (int k = 3*S+1; k < 3*S+DN; k++) @(negedge clk);
            chk(bus_rdata[d] === 1'b1, $sformatf("R5 busy at last down poll dom%0d", d), bus_rdata[d], 1);
            @(negedge clk);
            chk(bus_rdata[d] === 1'b0, $sformatf("R5 busy after down window dom%0d", d), bus_rdata[d], 0);
            rd(OFS_ERR, v);
            chk(v[d] === 1'b1, $sformatf("R5 down timeout error dom%0d", d), v, 32'(1) << d);
            chk(ctl_of(d) === 4'b0011, $sformatf("R5 outputs held dom%0d", d), ctl_of(d), 4'b0011);
        end else begin
            for (int k = 0; k < DN + 2 && !fin; k++) begin
                @(negedge clk);
                if (bus_rdata[d] === 1'b0) fin = 1;
            end
            rd(OFS_ERR, v);
            chk(fin && v[d] === 1'b0, $sformatf("R3 down completes on ack dom%0d", d), v, 0);
            rd(OFS_ACK, v);
            chk(v[d] === 1'b1, $sformatf("R8 ack register dom%0d", d), v, 32'(1) << d);
        end
    endtask

    task automatic run_up(input int d, input bit stuck);
        bit bad = 0;
        int ka = -1;
        logic [31:0] v;
        sw_dly[d] = $urandom_range(0, 3);
        if (stuck) begin stuck_val[d] = 1'b1; stuck_en[d] = 1'b1; end
        bus_raddr = OFS_BUSY;
        wr(OFS_CMD, 32'(1) << (CMD_UP_LSB + d));
        if (stuck) begin
            for (int k = 0; k < UP; k++) @(negedge clk);
            chk(bus_rdata[d] === 1'b1, $sformatf("R5 busy at last up poll dom%0d", d), bus_rdata[d], 1);
            @(negedge clk);
            chk(bus_rdata[d] === 1'b0, $sformatf("R5 busy after up window dom%0d", d), bus_rdata[d], 0);
            rd(OFS_ERR, v);
            chk(v[d] === 1'b1, $sformatf("R5 up timeout error dom%0d", d), v, 32'(1) << d);
            chk(ctl_of(d) === 4'b0010, $sformatf("R5 up outputs held dom%0d", d), ctl_of(d), 4'b0010);
        end else begin
            for (int k = 0; k <= UP + 3*S; k++) begin
                @(negedge clk);
                if (pdn[d] !== 1'b0) bad = 1;
                if (ka < 0 && rst_rel[d] === 1'b1) ka = k;
                if (ka < 0 && (iso[d] !== 1'b1 || clk_en[d] !== 1'b0)) bad = 1;
                if (ka >= 0) begin
                    if (iso[d] !== (k < ka + S) || clk_en[d] !== (k >= ka + 2*S) ||
                        bus_rdata[d] !== (k < ka + 3*S)) bad = 1;
                    if (k == ka + 3*S) break;
                end
            end
            chk(!bad && ka >= 1 && ka <= UP, $sformatf("R4 up order dom%0d", d), ctl_of(d), 4'b1100);
            rd(OFS_ERR, v);
            chk(v[d] === 1'b0, $sformatf("R4 up no error dom%0d", d), v, 0);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        for (int d = 0; d < N; d++) begin sw_dly[d] = 1; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R8 register read-back
        chk({clk_en, rst_rel, iso, pdn} === {{N{1'b1}}, {N{1'b1}}, {N{1'b0}}, {N{1'b0}}},
            "R1 reset outputs", {clk_en, rst_rel, iso, pdn}, {{N{1'b1}}, {N{1'b1}}, {2*N{1'b0}}});
        rd(OFS_CLK, v);  chk(v === 32'hF, "R8 clock register", v, 32'hF);
        rd(OFS_RST, v);  chk(v === 32'hF, "R8 reset register", v, 32'hF);
        rd(OFS_ISO, v);  chk(v === 32'h0, "R8 isolation register", v, 0);
        rd(OFS_PDN, v);  chk(v === 32'h0, "R8 switch register", v, 0);
        rd(OFS_BUSY, v); chk(v === 32'h0, "R1 busy after reset", v, 0);
        rd(OFS_ERR, v);  chk(v === 32'h0, "R1 error after reset", v, 0);
        rd(8'h40, v);    chk(v === 32'h0, "R8 unmapped offset", v, 0);

        // R2 R3 R4 sweep over every domain
        for (int d = 0; d < N; d++) begin
            run_down(d, 0);
            rd(OFS_PDN, v);
            chk(v === 32'(1) << d, $sformatf("R10 only dom%0d switched off", d), v, 32'(1) << d);
            run_up(d, 0);
        end

        // R10 all domains in one write
        wr(OFS_CMD, 32'hF);
        @(negedge clk);
        chk(clk_en === '0, "R10 all clocks gated at once", clk_en, 0);
        idle(3*S + DN + 4);
        chk(pdn === '1 && iso === '1 && rst_rel === '0, "R10 all powered down", pdn, 32'hF);
        wr(OFS_CMD, 32'hF << CMD_UP_LSB);
        idle(UP + 3*S + 4);
        chk(clk_en === '1 && iso === '0 && rst_rel === '1 && pdn === '0,
            "R10 all powered up", {clk_en, iso}, 8'hF0);

        // R6 power-up during power-down is ignored
        wr(OFS_CMD, 32'h2);
        wr(OFS_CMD, 32'h2 << CMD_UP_LSB);
        idle(3*S + DN + 4);
        chk(ctl_of(1) === 4'b0011, "R6 up ignored while busy", ctl_of(1), 4'b0011);
        run_up(1, 0);

        // R6 power-down during power-up is ignored
        run_down(3, 0);
        wr(OFS_CMD, 32'h8 << CMD_UP_LSB);
        wr(OFS_CMD, 32'h8);
        idle(UP + 3*S + 4);
        chk(ctl_of(3) === 4'b1100, "R6 down ignored while busy", ctl_of(3), 4'b1100);

        // R9 both bits in one write: power-down wins
        wr(OFS_CMD, (32'h4 << CMD_UP_LSB) | 32'h4);
        idle(3*S + DN + 4);
        chk(ctl_of(2) === 4'b0011, "R9 down wins", ctl_of(2), 4'b0011);
        run_up(2, 0);

        // R5 power-down timeout on every domain, R7 error clearing
        for (int d = 0; d < N; d++) begin
            run_down(d, 1);
            wr(OFS_ERR, 32'h0);
            @(negedge clk);
            rd(OFS_ERR, v);
            chk(v[d] === 1'b1, $sformatf("R7 write 0 keeps error dom%0d", d), v, 32'(1) << d);
            wr(OFS_ERR, 32'(1) << d);
            @(negedge clk);
            rd(OFS_ERR, v);
            chk(v === 32'h0, $sformatf("R7 write 1 clears error dom%0d", d), v, 0);
            stuck_en[d] = 1'b0;
            idle(8);
            run_up(d, 0);
        end

        // R5 power-up timeout, then recovery
        run_down(0, 0);
        run_up(0, 1);
        wr(OFS_ERR, 32'h1);
        stuck_en[0] = 1'b0;
        idle(8);
        run_up(0, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule